// File: doc/BRIEF.md
# Flow-Control Credit Initialization Controller

This block brings up credit accounting on one side of a serial link before any transaction packet may cross it. It keeps sending 4-byte credit-advertisement packets that carry its own receive credits for three traffic classes: posted, non-posted and completion. At the same time it decodes the partner's advertisements and keeps the limits the partner reports. Once the partner's three classes are all known, it switches to second-phase advertisements. It raises `init_done` when the partner confirms, and the surrounding logic uses that flag to gate packet traffic.

Packets go out one byte per accepted transfer on a valid/ready port. Received packets arrive whole, as a 32-bit word with a strobe. A separate pulse tells the block that the partner has started sending transaction packets. Every credit field is 12 bits wide. An advertised value of zero means the pool is unlimited.

Top module: `fcinit_ctrl`

## Requirements
- R1: A packet is four bytes, sent one byte per cycle in which `tx_valid` and `tx_ready` are both high, in this order: type code; header credits [7:0]; {data credits [3:0] in bits 7:4, header credits [11:8] in bits 3:0}; data credits [11:4]. While `tx_ready` is low, `tx_valid` and `tx_byte` hold.
- R2: Type codes are base + 16×class, with class posted=0, non-posted=1, completion=2. The first-phase base is 0x40 and the second-phase base is 0xC0, so the codes are 0x40/0x50/0x60 and 0xC0/0xD0/0xE0.
- R3: From reset, the first-phase packets cycle posted, non-posted, completion, and repeat. Each packet carries the local credits of its class, sampled when the packet starts.
- R4: A received packet with any first- or second-phase code records that class's partner header and data limits and sets its bit in `ptn_got` (bit = class). This happens only the first time for each class, and later packets for that class change nothing.
- R5: A recorded header or data value of zero sets the matching bit of `ptn_hdr_inf` / `ptn_dat_inf`.
- R6: First-phase sending continues until all three `ptn_got` bits are set. The packet already in progress then completes unchanged. The next packet is a second-phase posted packet, and the sequence cycles through the classes from there.
- R7: In the second phase, a received second-phase packet or a pulse on `rx_txn_start` sets `init_done`. In the first phase, neither of these sets it.
- R8: `init_done` stays high until reset. After it rises, a packet in progress completes, and no further packet starts.
- R9: A received packet whose type code is not one of the six codes changes no output.
- R10: During reset, `tx_valid`, `init_done`, `ptn_got`, the limits and the unlimited flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_hdr | input | 36 | Local header credits, class c at [12c+11:12c] |
| loc_dat | input | 36 | Local data credits, class c at [12c+11:12c] |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Link accepts the byte this cycle |
| tx_byte | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received packet strobe |
| rx_pkt | input | 32 | Received packet, byte 0 in [31:24] |
| rx_txn_start | input | 1 | Partner has begun transaction traffic |
| ptn_got | output | 3 | Partner limits captured, one bit per class |
| ptn_hdr | output | 36 | Partner header limits, class c at [12c+11:12c] |
| ptn_dat | output | 36 | Partner data limits, class c at [12c+11:12c] |
| ptn_hdr_inf | output | 3 | Partner header pool unlimited, per class |
| ptn_dat_inf | output | 3 | Partner data pool unlimited, per class |
| init_done | output | 1 | Exchange complete; traffic may flow |

## Verification
The bench builds the block with its default type-code bases, 0x40 and 0xC0, and a 12-bit credit field. With these values it can drive all six valid codes, plus near-miss codes (0x41, and 0x70, which is one class past the last). It holds `tx_ready` low while partner packets arrive, so that the phase change falls on a packet that is already loaded and waiting. Local credit values use every nibble, including zero, so a swap of any half-byte in the split fields shows up.

// File: rtl/fcinit_pkg.sv
package fcinit_pkg;
  localparam int CW   = 12;
  localparam int NCLS = 3;
  localparam int PKTW = 32;

  typedef enum logic [1:0] {CLS_P = 2'd0, CLS_NP = 2'd1, CLS_CPL = 2'd2} fc_cls_e;

  function automatic logic [7:0] type_code(input logic [7:0] base, input logic [1:0] c);
    return base + {2'b00, c, 4'h0};
  endfunction

  function automatic logic [PKTW-1:0] pack_pkt(input logic [7:0] t,
                                               input logic [CW-1:0] h,
                                               input logic [CW-1:0] d);
    return {t, h[7:0], d[3:0], h[11:8], d[11:4]};
  endfunction

  function automatic logic [CW-1:0] hdr_of(input logic [PKTW-1:0] p);
    return {p[11:8], p[23:16]};
  endfunction

  function automatic logic [CW-1:0] dat_of(input logic [PKTW-1:0] p);
    return {p[7:0], p[15:12]};
  endfunction

  function automatic fc_cls_e cls_next(input fc_cls_e c);
    return (c == CLS_CPL) ? CLS_P : fc_cls_e'(c + 2'd1);
  endfunction
endpackage

// File: rtl/fcinit_rx.sv
module fcinit_rx
  import fcinit_pkg::*;
#(
  parameter logic [7:0] P1_BASE = 8'h40,
  parameter logic [7:0] P2_BASE = 8'hC0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic [PKTW-1:0]      rx_pkt,
  output logic [NCLS-1:0]      got,
  output logic [NCLS*CW-1:0]   hdr_lim,
  output logic [NCLS*CW-1:0]   dat_lim,
  output logic [NCLS-1:0]      hdr_inf,
  output logic [NCLS-1:0]      dat_inf,
  output logic                 rx_p2_hit,
  output logic                 rx_known
);
  logic [NCLS-1:0] m1, m2, cap;
  logic [CW-1:0]   rh, rd;

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      m1[c] = (rx_pkt[31:24] == type_code(P1_BASE, 2'(c)));
      m2[c] = (rx_pkt[31:24] == type_code(P2_BASE, 2'(c)));
    end
    cap       = {NCLS{rx_valid}} & (m1 | m2) & ~got;
    rx_p2_hit = rx_valid & (|m2);
    rx_known  = |(m1 | m2);
    rh        = hdr_of(rx_pkt);
    rd        = dat_of(rx_pkt);
  end

  for (genvar gc = 0; gc < NCLS; gc++) begin : g_cls
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        got[gc]                <= 1'b0;
        hdr_lim[gc*CW +: CW]   <= '0;
        dat_lim[gc*CW +: CW]   <= '0;
        hdr_inf[gc]            <= 1'b0;
        dat_inf[gc]            <= 1'b0;
      end else if (cap[gc]) begin
        got[gc]                <= 1'b1;
        hdr_lim[gc*CW +: CW]   <= rh;
        dat_lim[gc*CW +: CW]   <= rd;
        hdr_inf[gc]            <= (rh == '0);
        dat_inf[gc]            <= (rd == '0);
      end
    end
  end
endmodule

// File: rtl/fcinit_seq.sv
module fcinit_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic got_all,
  input  logic rx_p2_hit,
  input  logic rx_txn_start,
  output logic ph2,
  output logic done,
  output logic ph_go,
  output logic done_go
);
  assign ph_go   = !ph2 && got_all;
  assign done_go = ph2 && !done && (rx_p2_hit || rx_txn_start);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph2  <= 1'b0;
      done <= 1'b0;
    end else begin
      if (ph_go)   ph2  <= 1'b1;
      if (done_go) done <= 1'b1;
    end
  end
endmodule

// File: rtl/fcinit_tx.sv
module fcinit_tx
  import fcinit_pkg::*;
#(
  parameter logic [7:0] P1_BASE = 8'h40,
  parameter logic [7:0] P2_BASE = 8'hC0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ph2,
  input  logic               ph_go,
  input  logic [NCLS*CW-1:0] loc_hdr,
  input  logic [NCLS*CW-1:0] loc_dat,
  input  logic               tx_ready,
  output logic               tx_valid,
  output logic [7:0]         tx_byte,
  output logic               tx_load
);
  logic            busy;
  logic [1:0]      bidx;
  logic [PKTW-1:0] pkt;
  fc_cls_e         nxt_cls, ld_cls;
  logic            ld_ph2;
  logic [7:0]      ld_type;

  assign tx_load  = en && !busy;
  assign ld_cls   = ph_go ? CLS_P : nxt_cls;
  assign ld_ph2   = ph2 || ph_go;
  assign ld_type  = type_code(ld_ph2 ? P2_BASE : P1_BASE, ld_cls);
  assign tx_valid = busy;

  always_comb begin
    case (bidx)
      2'd0:    tx_byte = pkt[31:24];
      2'd1:    tx_byte = pkt[23:16];
      2'd2:    tx_byte = pkt[15:8];
      default: tx_byte = pkt[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bidx    <= 2'd0;
      pkt     <= '0;
      nxt_cls <= CLS_P;
    end else begin
      if (tx_load) begin
        pkt     <= pack_pkt(ld_type, loc_hdr[int'(ld_cls)*CW +: CW],
                            loc_dat[int'(ld_cls)*CW +: CW]);
        busy    <= 1'b1;
        bidx    <= 2'd0;
        nxt_cls <= cls_next(ld_cls);
      end else if (ph_go) begin
        nxt_cls <= CLS_P;
      end
      if (busy && tx_ready) begin
        bidx <= bidx + 2'd1;
        if (bidx == 2'd3) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcinit_ctrl.sv
module fcinit_ctrl
  import fcinit_pkg::*;
#(
  parameter logic [7:0] P1_BASE = 8'h40,
  parameter logic [7:0] P2_BASE = 8'hC0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCLS*CW-1:0] loc_hdr,
  input  logic [NCLS*CW-1:0] loc_dat,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_byte,
  input  logic               rx_valid,
  input  logic [PKTW-1:0]    rx_pkt,
  input  logic               rx_txn_start,
  output logic [NCLS-1:0]    ptn_got,
  output logic [NCLS*CW-1:0] ptn_hdr,
  output logic [NCLS*CW-1:0] ptn_dat,
  output logic [NCLS-1:0]    ptn_hdr_inf,
  output logic [NCLS-1:0]    ptn_dat_inf,
  output logic               init_done
);
  logic rx_p2_hit, rx_known;
  logic ph2, ph_go, done_go, tx_load;

  fcinit_rx #(.P1_BASE(P1_BASE), .P2_BASE(P2_BASE)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_pkt(rx_pkt),
    .got(ptn_got), .hdr_lim(ptn_hdr), .dat_lim(ptn_dat),
    .hdr_inf(ptn_hdr_inf), .dat_inf(ptn_dat_inf),
    .rx_p2_hit(rx_p2_hit), .rx_known(rx_known)
  );

  fcinit_seq u_seq (
    .clk(clk), .rst_n(rst_n), .got_all(&ptn_got), .rx_p2_hit(rx_p2_hit),
    .rx_txn_start(rx_txn_start), .ph2(ph2), .done(init_done),
    .ph_go(ph_go), .done_go(done_go)
  );

  fcinit_tx #(.P1_BASE(P1_BASE), .P2_BASE(P2_BASE)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(!init_done), .ph2(ph2), .ph_go(ph_go),
    .loc_hdr(loc_hdr), .loc_dat(loc_dat), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_load(tx_load)
  );
endmodule

// File: rtl/fcinit_chk.sv
module fcinit_chk
  import fcinit_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic [7:0]         tx_byte,
  input logic               rx_valid,
  input logic               rx_known,
  input logic [NCLS-1:0]    ptn_got,
  input logic [NCLS*CW-1:0] ptn_hdr,
  input logic [NCLS*CW-1:0] ptn_dat,
  input logic               init_done,
  input logic               ph2,
  input logic               ph_go,
  input logic               done_go,
  input logic               tx_load
);
  logic [NCLS*CW-1:0] lmask;
  always_comb
    for (int c = 0; c < NCLS; c++) lmask[c*CW +: CW] = {CW{ptn_got[c]}};

  // R1
  hold_while_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

  // R4
  keep_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((ptn_hdr ^ $past(ptn_hdr)) | (ptn_dat ^ $past(ptn_dat))) & $past(lmask)) == '0);

  // R4
  got_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(ptn_got) & ~ptn_got) == '0);

  // R6
  ph2_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_go |-> &ptn_got);

  // R7
  done_in_ph2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_go |-> ph2);

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8
  no_new_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !tx_load);

  // R9
  unknown_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_known |=> $stable(ptn_got) && $stable(ptn_hdr) && $stable(ptn_dat));
endmodule

bind fcinit_ctrl fcinit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_known(rx_known),
  .ptn_got(ptn_got), .ptn_hdr(ptn_hdr), .ptn_dat(ptn_dat),
  .init_done(init_done), .ph2(ph2), .ph_go(ph_go), .done_go(done_go),
  .tx_load(tx_load)
);

// File: tb/test_fcinit_ctrl.sv
module test_fcinit_ctrl;
  localparam int CLK_P = 10;
  localparam logic [7:0] T1P = 8'h40, T1N = 8'h50, T1C = 8'h60;
  localparam logic [7:0] T2P = 8'hC0, T2N = 8'hD0, T2C = 8'hE0;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [35:0] loc_hdr, loc_dat;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_byte;
  logic        rx_valid = 1'b0, rx_txn_start = 1'b0;
  logic [31:0] rx_pkt = '0;
  logic [2:0]  ptn_got, ptn_hdr_inf, ptn_dat_inf;
  logic [35:0] ptn_hdr, ptn_dat;
  logic        init_done;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [11:0] lh[3], ld[3];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic [31:0] acc = '0;
  int          nb = 0;

  always #(CLK_P/2) clk = ~clk;

  fcinit_ctrl i_fcinit_ctrl (
    .clk(clk), .rst_n(rst_n), .loc_hdr(loc_hdr), .loc_dat(loc_dat),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_pkt(rx_pkt), .rx_txn_start(rx_txn_start),
    .ptn_got(ptn_got), .ptn_hdr(ptn_hdr), .ptn_dat(ptn_dat),
    .ptn_hdr_inf(ptn_hdr_inf), .ptn_dat_inf(ptn_dat_inf), .init_done(init_done)
  );

  assign loc_hdr = {lh[2], lh[1], lh[0]};
  assign loc_dat = {ld[2], ld[1], ld[0]};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected wire image of a packet, assembled byte by byte from R1.
  function automatic logic [31:0] wire_img(input logic [7:0] t, input logic [11:0] h,
                                           input logic [11:0] d);
    logic [7:0] b1, b2, b3;
    b1 = h[7:0];
    b2 = {d[3:0], h[11:8]};
    b3 = d[11:4];
    return {t, b1, b2, b3};
  endfunction

  task automatic expect_pkt(input logic [7:0] t, input int c, input string tag);
    q_exp.push_back(wire_img(t, lh[c], ld[c]));
    q_tag.push_back(tag);
  endtask

  // Monitor: opens tx_ready while items are owed, compares each finished packet.
  always @(negedge clk) begin
    if (!rst_n) begin
      tx_ready = 1'b0;
      nb = 0;
    end else begin
      tx_ready = (q_exp.size() > 0);
      if (tx_valid && tx_ready) begin
        acc = {acc[23:0], tx_byte};
        nb++;
        if (nb == 4) begin
          check(q_tag.pop_front(), acc, q_exp.pop_front());
          nb = 0;
        end
      end
    end
  end

  task automatic drain();
    while (q_exp.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] t, input logic [11:0] h, input logic [11:0] d);
    rx_pkt   = wire_img(t, h, d);
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic txn_pulse();
    rx_txn_start = 1'b1;
    @(negedge clk);
    rx_txn_start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    lh[0] = 12'h9A5; ld[0] = 12'h3C7;
    lh[1] = 12'h012; ld[1] = 12'hF00;
    lh[2] = 12'h000; ld[2] = 12'h000;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 tx_valid", tx_valid, 0);
    check("R10 init_done", init_done, 0);
    check("R10 ptn_got", ptn_got, 0);
    check("R10 limits", {ptn_hdr, ptn_dat, ptn_hdr_inf, ptn_dat_inf}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 / R1 / R2: first-phase rotation
    expect_pkt(T1P, 0, "R3 p1 posted");
    expect_pkt(T1N, 1, "R3 p1 nonposted");
    expect_pkt(T1C, 2, "R3 p1 completion");
    expect_pkt(T1P, 0, "R3 p1 posted again");
    expect_pkt(T1N, 1, "R1 p1 nonposted again");
    drain();
    check("R1 stalled valid", tx_valid, 1);
    check("R3 stalled next is completion", tx_byte, T1C);

    // R4 capture and first-only
    rx_send(T1P, 12'h123, 12'h456);
    check("R4 got posted", ptn_got, 3'b001);
    check("R4 posted limits", {ptn_hdr[11:0], ptn_dat[11:0]}, {12'h123, 12'h456});
    rx_send(T1P, 12'h777, 12'h888);
    check("R4 second posted ignored", {ptn_hdr[11:0], ptn_dat[11:0]}, {12'h123, 12'h456});
    // R9 unknown codes
    rx_send(8'h70, 12'h111, 12'h222);
    rx_send(8'h41, 12'h333, 12'h444);
    check("R9 unknown got", ptn_got, 3'b001);
    check("R9 unknown limits", {ptn_hdr, ptn_dat}, {24'h0, 12'h123, 24'h0, 12'h456});
    // R4 / R5 via second-phase packet during first phase
    rx_send(T2N, 12'h000, 12'hABC);
    check("R4 got nonposted from p2", ptn_got, 3'b011);
    check("R5 nonposted hdr unlimited", {ptn_hdr_inf, ptn_dat_inf}, {3'b010, 3'b000});
    check("R7 p2 packet in phase1 no done", init_done, 0);
    txn_pulse();
    check("R7 traffic in phase1 no done", init_done, 0);
    check("R6 still phase1", tx_byte, T1C);
    rx_send(T1C, 12'h800, 12'h000);
    check("R5 completion data unlimited", {ptn_got, ptn_hdr_inf, ptn_dat_inf}, {3'b111, 3'b010, 3'b100});
    check("R4 completion hdr", ptn_hdr[35:24], 12'h800);

    // R6 in-flight finishes, then second phase from posted
    expect_pkt(T1C, 2, "R6 in-flight p1 completion");
    expect_pkt(T2P, 0, "R6 p2 posted");
    expect_pkt(T2N, 1, "R6 p2 nonposted");
    expect_pkt(T2C, 2, "R2 p2 completion");
    expect_pkt(T2P, 0, "R6 p2 posted again");
    drain();
    check("R7 phase2 unconfirmed", init_done, 0);
    rx_send(T2C, 12'h055, 12'h066);
    check("R7 p2 packet sets done", init_done, 1);
    check("R4 completion kept", ptn_hdr[35:24], 12'h800);
    expect_pkt(T2N, 1, "R8 in-flight completes");
    drain();
    repeat (10) @(negedge clk);
    check("R8 no new packet", tx_valid, 0);
    rx_send(8'h00, 12'h0, 12'h0);
    check("R8 done sticky", init_done, 1);

    // Second run: completion by traffic start
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 reset clears done", {init_done, ptn_got}, 0);
    lh[0] = 12'h5E1; ld[0] = 12'h0D2;
    lh[1] = 12'hC04; ld[1] = 12'h7B9;
    lh[2] = 12'h3A6; ld[2] = 12'h18F;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rx_send(T1N, 12'h010, 12'h020);
    rx_send(T1C, 12'h030, 12'h040);
    rx_send(T1P, 12'h050, 12'h060);
    check("R4 all captured run2", ptn_got, 3'b111);
    check("R5 no unlimited run2", {ptn_hdr_inf, ptn_dat_inf}, 0);
    expect_pkt(T1P, 0, "R6 run2 in-flight");
    expect_pkt(T2P, 0, "R6 run2 p2 posted");
    expect_pkt(T2N, 1, "R6 run2 p2 nonposted");
    drain();
    txn_pulse();
    check("R7 traffic sets done", init_done, 1);
    expect_pkt(T2C, 2, "R8 run2 in-flight");
    drain();
    repeat (6) @(negedge clk);
    check("R8 run2 idle", tx_valid, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule